// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Back Data Cache Controller

This block sits between a processor's load/store port and a line-wide backing memory. Each processor access names a byte address and moves one 32-bit word. The controller splits the address into tag, set index and line offset, and reads all four ways of the selected set at once. A hit is served from the cache without touching memory. A miss picks a victim way. If that victim holds modified data, the controller writes the whole 16-byte line back to memory. It then reads the missing line in and completes the original load or store on the newly filled line.

Stores use a write-back policy: a store that hits changes only the cached line and marks it modified. A store that misses first allocates the line and then merges the word into it. Ways with no valid data are used first. Once all four ways of a set are valid, a three-bit tree pseudo-LRU state kept for each set chooses the victim. The address width and the set count are parameters, so a small instance can be checked against a software model of memory.

Top module: `cache_ctrl`

## Requirements
- R1: A byte address splits into offset = bits [3:0], index = the next INDEX_W bits, and tag = the remaining upper bits. Address bits [3:2] select the 32-bit word within the line as bits [32*sel +: 32]. Address bits [1:0] are ignored.
- R2: A load that hits returns the stored word on cpu_rdata with a one-cycle cpu_done pulse. The pulse is visible after the second rising edge counted from the edge that accepts the request. A hit issues no memory request.
- R3: A store that hits updates only the cached word. Backing memory keeps its old value until that line is evicted.
- R4: When a miss picks a victim that is both valid and modified, the controller writes its full line with mem_we=1 at {victim tag, index, 4'b0000}, and only then reads the missing line with mem_we=0 at {tag, index, 4'b0000}. Every memory address has offset zero. mem_req, mem_we and mem_addr stay stable until mem_ack. A clean victim causes no write.
- R5: A store that misses reads the line from memory, then merges the word into the cached copy. The freshly filled line starts unmodified.
- R6: The victim is the lowest-numbered invalid way if one exists. Otherwise it is chosen by the tree bits: t[0]=0 selects the pair {0,1} and t[0]=1 selects {2,3}; within the first pair t[1] selects way t[1], and within the second pair t[2] selects way 2+t[2].
- R7: Every hit or completed miss points the tree bits of its set away from the way it used.
- R8: cpu_ready is high only when a new request can be accepted, and it stays low during lookup and the entire miss service, including while mem_req is high.
- R9: A synchronous reset clears all valid, modified and tree bits. After reset, cpu_ready=1, mem_req=0 and cpu_done=0, and the first four distinct lines of a set fill ways 0 to 3 in that order.
- R10: Sets are independent: filling or evicting lines in one set does not change hits in another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Request strobe, taken when cpu_ready is high |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load result, valid with cpu_done |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = line write-back, 0 = line fill |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | 128 | Line being written back |
| mem_ack | input | 1 | One-cycle memory completion |
| mem_rdata | input | 128 | Fill line, valid with mem_ack |

## Verification
The hardest case to reach is a dirty eviction chosen by the tree bits rather than by an empty way. Reaching it needs all four ways of a set valid, with a modified line sitting exactly where the tree points. The bench gets there with a hand-planned sequence in one set: a store hit, a store miss, then two more fills. Two further misses each then evict a different modified line, and the bench checks the write-back address and data and that the write-back comes before the fill. A second set is filled from reset to show the empty-way-first order, and a long mixed load/store run is compared word by word against a model of memory.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int WAYS   = 4;
  localparam int OFF_W  = 4;
  localparam int LINE_W = 128;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {ST_IDLE, ST_LOOKUP, ST_WRITEBACK, ST_FILL, ST_RESPOND} cc_state_e;

  function automatic logic [1:0] plru_victim(input logic [2:0] t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  function automatic logic [2:0] plru_touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line, input logic [1:0] sel);
    return line[WORD_W*sel +: WORD_W];
  endfunction

  function automatic logic [LINE_W-1:0] merge_word(input logic [LINE_W-1:0] line, input logic [1:0] sel,
                                                   input logic [WORD_W-1:0] data);
    logic [LINE_W-1:0] n;
    n = line;
    n[WORD_W*sel +: WORD_W] = data;
    return n;
  endfunction
endpackage

// File: rtl/cache_way_array.sv
module cache_way_array #(
  parameter int INDEX_W = 3,
  parameter int TAG_W   = 9,
  parameter int LINE_W  = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INDEX_W-1:0] idx,
  input  logic               fill_en,
  input  logic               store_en,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [LINE_W-1:0]  wr_line,
  output logic               rd_valid,
  output logic               rd_dirty,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [LINE_W-1:0]  rd_line
);
  localparam int SETS = 1 << INDEX_W;

  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (store_en) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= wr_tag;
    if (fill_en || store_en) line_q[idx] <= wr_line;
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_line  = line_q[idx];
endmodule

// File: rtl/cache_plru_array.sv
module cache_plru_array
  import cache_pkg::*;
#(
  parameter int INDEX_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INDEX_W-1:0] idx,
  input  logic               touch_en,
  input  logic [1:0]         touch_way,
  output logic [2:0]         tree
);
  localparam int SETS = 1 << INDEX_W;

  logic [2:0] tree_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= 3'b000;
    end else if (touch_en) begin
      tree_q[idx] <= plru_touch(tree_q[idx], touch_way);
    end
  end

  assign tree = tree_q[idx];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int INDEX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - INDEX_W - OFF_W;

  cc_state_e state_q, state_d;

  logic [TAG_W-1:0]   lat_tag;
  logic [INDEX_W-1:0] lat_idx;
  logic [1:0]         lat_sel;
  logic               lat_we;
  logic [WORD_W-1:0]  lat_wdata;
  logic [1:0]         vic_q;

  logic [WAYS-1:0]   way_valid, way_dirty, hit_vec, fill_en, store_en;
  logic [TAG_W-1:0]  way_tag  [WAYS];
  logic [LINE_W-1:0] way_line [WAYS];
  logic [2:0]        plru_bits;

  // named internal events
  logic        lookup_hit, access_evt, fill_evt;
  logic [1:0]  hit_way, acc_way, inv_way, pick_way;
  logic        inv_found;
  logic [LINE_W-1:0] acc_line, wr_line;

  always_comb begin
    hit_way   = 2'd0;
    inv_found = 1'b0;
    inv_way   = 2'd0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      hit_vec[w] = way_valid[w] && (way_tag[w] == lat_tag);
      if (hit_vec[w]) hit_way = 2'(w);
      if (!way_valid[w]) begin
        inv_found = 1'b1;
        inv_way   = 2'(w);
      end
    end
  end

  assign pick_way   = inv_found ? inv_way : plru_victim(plru_bits);
  assign lookup_hit = (state_q == ST_LOOKUP) && (|hit_vec);
  assign access_evt = lookup_hit || (state_q == ST_RESPOND);
  assign fill_evt   = (state_q == ST_FILL) && mem_ack;
  assign acc_way    = (state_q == ST_RESPOND) ? vic_q : hit_way;
  assign acc_line   = way_line[acc_way];
  assign wr_line    = fill_evt ? mem_rdata : merge_word(acc_line, lat_sel, lat_wdata);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign fill_en[w]  = fill_evt && (vic_q == 2'(w));
    assign store_en[w] = access_evt && lat_we && (acc_way == 2'(w));
    cache_way_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_way (
      .clk(clk), .rst(rst), .idx(lat_idx),
      .fill_en(fill_en[w]), .store_en(store_en[w]),
      .wr_tag(lat_tag), .wr_line(wr_line),
      .rd_valid(way_valid[w]), .rd_dirty(way_dirty[w]),
      .rd_tag(way_tag[w]), .rd_line(way_line[w])
    );
  end

  cache_plru_array #(.INDEX_W(INDEX_W)) u_plru (
    .clk(clk), .rst(rst), .idx(lat_idx),
    .touch_en(access_evt), .touch_way(acc_way), .tree(plru_bits)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:      if (cpu_req) state_d = ST_LOOKUP;
      ST_LOOKUP:    if (|hit_vec) state_d = ST_IDLE;
                    else if (way_valid[pick_way] && way_dirty[pick_way]) state_d = ST_WRITEBACK;
                    else state_d = ST_FILL;
      ST_WRITEBACK: if (mem_ack) state_d = ST_FILL;
      ST_FILL:      if (mem_ack) state_d = ST_RESPOND;
      ST_RESPOND:   state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cpu_done <= 1'b0;
      vic_q    <= 2'd0;
    end else begin
      state_q  <= state_d;
      cpu_done <= access_evt;
      if (state_q == ST_LOOKUP && !(|hit_vec)) vic_q <= pick_way;
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE && cpu_req) begin
      lat_tag   <= cpu_addr[ADDR_W-1 -: TAG_W];
      lat_idx   <= cpu_addr[OFF_W +: INDEX_W];
      lat_sel   <= cpu_addr[3:2];
      lat_we    <= cpu_we;
      lat_wdata <= cpu_wdata;
    end
    if (access_evt && !lat_we) cpu_rdata <= pick_word(acc_line, lat_sel);
  end

  assign cpu_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_WRITEBACK) || (state_q == ST_FILL);
  assign mem_we    = (state_q == ST_WRITEBACK);
  assign mem_addr  = mem_we ? {way_tag[vic_q], lat_idx, {OFF_W{1'b0}}}
                            : {lat_tag, lat_idx, {OFF_W{1'b0}}};
  assign mem_wdata = way_line[vic_q];

  // R4: line-aligned memory addresses
  a_r4_mem_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));
  // R4: request held stable until acknowledged
  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R4: only a valid, modified line is written back
  a_r4_wb_dirty: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (way_valid[vic_q] && way_dirty[vic_q]));
  // R5: a filled line is valid and unmodified before the merge
  a_r5_fill_clean: assert property (@(posedge clk) disable iff (rst)
    fill_evt |=> (way_valid[vic_q] && !way_dirty[vic_q]));
  // R8: no new request accepted during miss service
  a_r8_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);
  // R2: at most one way matches a tag
  a_r2_single_hit: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOKUP) |-> $onehot0(hit_vec));
  // R2: completion is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);
  // R7: tree points away from the way just used
  a_r7_plru_away: assert property (@(posedge clk) disable iff (rst)
    access_evt |=> (plru_victim(plru_bits) != $past(acc_way)));
endmodule

// File: tb/tb_cache_ctrl.sv
`timescale 1ns/1ps
module tb_cache_ctrl;
  localparam int AW = 10;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic cpu_ready, cpu_done;
  logic [31:0] cpu_rdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [127:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;

  always #10 clk = ~clk;

  cache_ctrl #(.ADDR_W(AW), .INDEX_W(IW)) dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_checks = 0, n_fail = 0;
  logic [127:0] mem_line [64];
  logic [31:0]  ref_word [256];
  int n_fill = 0, n_wb = 0, seq = 0, wb_seq = 0, fill_seq = 0;
  logic [AW-1:0] wb_addr;
  logic [127:0] wb_line;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // backing memory model
  initial begin
    for (int i = 0; i < 64; i++)
      for (int k = 0; k < 4; k++) mem_line[i][32*k +: 32] = 32'hC0DE_0000 | 32'(i*4 + k);
    for (int i = 0; i < 256; i++) ref_word[i] = 32'hC0DE_0000 | 32'(i);
    forever begin
      @(negedge clk);
      if (mem_req && !rst) begin
        chk(cpu_ready == 1'b0, "R8 ready low in miss", cpu_ready, 0);
        chk(mem_addr[3:0] == 4'h0, "R4 aligned", mem_addr, mem_addr & ~10'hF);
        repeat (2) @(negedge clk);
        seq++;
        if (mem_we) begin
          mem_line[mem_addr[9:4]] = mem_wdata;
          n_wb++; wb_addr = mem_addr; wb_line = mem_wdata; wb_seq = seq;
        end else begin
          mem_rdata = mem_line[mem_addr[9:4]];
          n_fill++; fill_seq = seq;
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    lat = 1;
    while (!cpu_done) begin
      @(negedge clk);
      lat++;
    end
    rd = cpu_rdata;
    if (we) ref_word[a[9:2]] = d;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input int dfill, input int dwb, input string req);
    logic [31:0] r; int lat; int f0, w0;
    f0 = n_fill; w0 = n_wb;
    access(1'b0, a, 32'h0, r, lat);
    chk(r == ref_word[a[9:2]], req, r, ref_word[a[9:2]]);
    if (dfill >= 0) chk(n_fill - f0 == dfill, {req, " fill count"}, n_fill - f0, dfill);
    if (dwb >= 0)   chk(n_wb - w0 == dwb, {req, " writeback count"}, n_wb - w0, dwb);
    if (dfill == 0 && dwb == 0) chk(lat == 2, {req, " hit latency"}, lat, 2);
  endtask

  task automatic wr_chk(input logic [AW-1:0] a, input logic [31:0] d, input int dfill, input int dwb, input string req);
    logic [31:0] r; int lat; int f0, w0;
    f0 = n_fill; w0 = n_wb;
    access(1'b1, a, d, r, lat);
    chk(n_fill - f0 == dfill, {req, " fill count"}, n_fill - f0, dfill);
    chk(n_wb - w0 == dwb, {req, " writeback count"}, n_wb - w0, dwb);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R9 ready after reset", cpu_ready, 1);
    chk(mem_req == 1'b0, "R9 no mem req after reset", mem_req, 0);
    chk(cpu_done == 1'b0, "R9 no done after reset", cpu_done, 0);
  endtask

  task automatic t_read_basic;
    rd_chk(10'h008, 1, 0, "R9 first read misses");
    rd_chk(10'h00C, 0, 0, "R2 read hit");
    rd_chk(10'h00B, 0, 0, "R1 low bits ignored");
  endtask

  task automatic t_store_hit;
    wr_chk(10'h004, 32'h1111_2222, 0, 0, "R3 store hit");
    rd_chk(10'h004, 0, 0, "R3 read back");
    chk(mem_line[0][63:32] == 32'hC0DE_0001, "R3 memory untouched", mem_line[0][63:32], 32'hC0DE_0001);
  endtask

  task automatic t_store_miss;
    wr_chk(10'h048, 32'h3333_4444, 1, 0, "R5 store miss allocates");
    rd_chk(10'h048, 0, 0, "R5 merged word");
    rd_chk(10'h044, 0, 0, "R5 rest of line filled");
    chk(mem_line[4][95:64] == 32'hC0DE_0012, "R5 memory untouched", mem_line[4][95:64], 32'hC0DE_0012);
  endtask

  task automatic t_plru_evict;
    rd_chk(10'h080, 1, 0, "R6 fill way2");
    rd_chk(10'h0C0, 1, 0, "R6 fill way3");
    rd_chk(10'h100, 1, 1, "R4 dirty victim way0");
    chk(wb_addr == 10'h000, "R4 writeback address", wb_addr, 10'h000);
    chk(wb_line[63:32] == 32'h1111_2222, "R4 writeback data", wb_line[63:32], 32'h1111_2222);
    chk(wb_seq < fill_seq, "R4 writeback before fill", wb_seq, fill_seq);
    rd_chk(10'h140, 1, 0, "R7 clean victim way2");
    rd_chk(10'h0C0, 0, 0, "R7 way3 retained");
    rd_chk(10'h080, 1, 1, "R6 dirty victim way1");
    chk(wb_addr == 10'h040, "R4 second writeback address", wb_addr, 10'h040);
    chk(wb_line[95:64] == 32'h3333_4444, "R4 second writeback data", wb_line[95:64], 32'h3333_4444);
  endtask

  task automatic t_sets;
    rd_chk(10'h010, 1, 0, "R10 set1 fill way0");
    rd_chk(10'h004, 1, 0, "R3 evicted word from memory");
    rd_chk(10'h014, 0, 0, "R10 set1 unaffected");
    rd_chk(10'h050, 1, 0, "R9 set1 fill way1");
    rd_chk(10'h090, 1, 0, "R9 set1 fill way2");
    rd_chk(10'h0D0, 1, 0, "R9 set1 fill way3");
    rd_chk(10'h110, 1, 0, "R6 set1 tree picks way0");
    rd_chk(10'h054, 0, 0, "R6 way1 retained");
    rd_chk(10'h014, 1, 0, "R6 way0 was evicted");
  endtask

  task automatic t_random;
    logic [31:0] r; int lat;
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, 255) * 4);
      if ($urandom_range(0, 9) < 3) access(1'b1, a, $urandom, r, lat);
      else begin
        access(1'b0, a, 32'h0, r, lat);
        chk(r == ref_word[a[9:2]], "R1 random load", r, ref_word[a[9:2]]);
      end
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_read_basic();
    t_store_hit();
    t_store_miss();
    t_plru_evict();
    t_sets();
    t_random();
    finish_run();
  end
endmodule